// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with Non-Maskable Input

This block decides which interrupt a small 8-bit core takes next. It accepts one non-maskable pin, which is active low and edge-triggered, and four maskable vectors. Vectors 1 and 2 come from external request lines. Vectors 3 and 4 come from peripheral flag bits, and each of those has its own enable bit. A global enable gates every maskable vector. The non-maskable input does not depend on the global enable.

The block passes a request and a 3-bit vector number to the core. It uses a valid/ready style handshake. `irq_req` is the valid signal and `irq_ack` is the ready signal. While `irq_req` is high and `irq_ack` is low, the vector must not change. The request drops in the cycle after the acknowledge, and nothing is offered again until the arbiter re-evaluates. An acknowledge with no request raised is ignored.

The block keeps two in-service bits: one for the non-maskable routine and one for a maskable routine. It uses these bits to enforce nesting. A return strobe closes the innermost routine. Two combinational outputs tell the low-power logic whether a pending source should end WAIT or STOP.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A falling edge on `nmi_n` raises `irq_req` with `irq_vec` = 0 at the fourth rising clock edge after the pin falls, whatever `glob_en` is. The pin passes through two synchronizer flops, then a falling-edge detector, then a request latch.
- R2: The request latched by a non-maskable edge clears when vector 0 is acknowledged. A single edge yields exactly one request, even if the pin stays low.
- R3: A non-maskable request is raised while a maskable routine is in service. It is not raised while a non-maskable routine is in service, and it stays latched until that routine returns.
- R4: While a maskable routine is in service, no maskable request is raised.
- R5: Among pending maskable vectors the lowest number wins, and the order 1 > 2 > 3 > 4 is fixed. A pending non-maskable request wins over all of them. `irq_vec` never exceeds 4.
- R6: Vectors 1 and 2 are pending when `ext_req[0]` or `ext_req[1]` is high and `glob_en` is set. Vector 3 (`per_flag[0]`) and vector 4 (`per_flag[1]`) are pending only when `glob_en` and their own `per_en` bit are both set.
- R7: Peripheral flags are level requests. A flag that stays high while the core is busy is served once the core becomes free.
- R8: `wake_wait` is high whenever the non-maskable latch is set or any maskable vector is pending as defined in R6.
- R9: `wake_stop` is high when the non-maskable latch is set, when vector 1 or 2 is pending, or when a pending peripheral vector has its bit set in `STOP_MASK`. By default only vector 3 is STOP-capable. `wake_stop` implies `wake_wait`.
- R10: `rst_n` low clears the request, the latch, the synchronizer and both in-service bits at once, even mid-routine.
- R11: While `irq_req` is high and `irq_ack` is low, `irq_req` and `irq_vec` hold. `irq_req` is low in the cycle after an acknowledge.
- R12: On `irq_reti`, the non-maskable in-service bit is cleared if it is set. Otherwise the maskable bit is cleared. A request waiting on the cleared level is raised at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_n | input | 1 | Non-maskable pin, falling-edge triggered |
| glob_en | input | 1 | Global enable for maskable vectors |
| ext_req | input | 2 | External request lines for vectors 1 and 2 |
| per_flag | input | 2 | Peripheral flags for vectors 3 and 4 |
| per_en | input | 2 | Per-peripheral enables |
| irq_ack | input | 1 | Core accepts the offered vector (ready) |
| irq_reti | input | 1 | Core returns from the current routine |
| irq_req | output | 1 | Interrupt request to the core (valid) |
| irq_vec | output | 3 | Vector number: 0 non-maskable, 1 to 4 maskable |
| wake_wait | output | 1 | A source may end WAIT |
| wake_stop | output | 1 | A source may end STOP |

## Verification
Each result has its own latency:
- The wake outputs follow the enabled inputs in the same cycle.
- A maskable request appears one edge after it becomes pending and the core is free.
- A non-maskable request appears four edges after the pin falls. The wake outputs see that request one edge earlier, once the latch is set.
- `irq_req` drops at the edge that takes the acknowledge.
- A request held back by an in-service level appears one edge after the edge that takes the return strobe.

The bench applies inputs at the falling edge and compares all outputs one nanosecond later against a behavioural model. The model is advanced at each rising edge. Directed checks are placed at exactly these edge counts.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int VEC_W = 3;
  typedef logic [VEC_W-1:0] vec_t;
  localparam vec_t NMI_VEC = vec_t'(0);
endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic svc_clr,
  output logic latch_q
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   fall;

  assign fall = last_q & ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      last_q  <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], pin_n};
      last_q  <= sync_q[SYNC_STAGES-1];
      latch_q <= fall | (latch_q & ~svc_clr);
    end
  end

  AST_NMI_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> latch_q); // R1
  AST_NMI_SVC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_clr && !fall) |=> !latch_q); // R2
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_EXT = 2,
  parameter int NUM_PER = 2,
  localparam int NUM_MASK = NUM_EXT + NUM_PER
) (
  input  logic                glob_en,
  input  logic [NUM_EXT-1:0]  ext_req,
  input  logic [NUM_PER-1:0]  per_flag,
  input  logic [NUM_PER-1:0]  per_en,
  output logic [NUM_MASK-1:0] pend,
  output logic                any_pend,
  output vec_t                win_vec
);
  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    assign pend[i] = ext_req[i] & glob_en;
  end
  for (genvar j = 0; j < NUM_PER; j++) begin : g_per
    assign pend[NUM_EXT+j] = per_flag[j] & per_en[j] & glob_en;
  end

  assign any_pend = |pend;

  always_comb begin
    win_vec = NMI_VEC;
    for (int k = NUM_MASK - 1; k >= 0; k--) begin
      if (pend[k]) win_vec = vec_t'(k + 1);
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_MASK = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_pend,
  input  logic mask_any,
  input  vec_t mask_win,
  input  logic ack,
  input  logic reti,
  output logic req_q,
  output vec_t vec_q,
  output logic svc_nmi
);
  logic nmi_act;
  logic mask_act;
  logic taken;

  assign taken   = req_q & ack;
  assign svc_nmi = taken & (vec_q == NMI_VEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      vec_q <= NMI_VEC;
    end else if (req_q) begin
      if (ack) req_q <= 1'b0;
    end else if (nmi_pend && !nmi_act) begin
      req_q <= 1'b1;
      vec_q <= NMI_VEC;
    end else if (mask_any && !nmi_act && !mask_act) begin
      req_q <= 1'b1;
      vec_q <= mask_win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_act  <= 1'b0;
      mask_act <= 1'b0;
    end else begin
      if (reti) begin
        if (nmi_act) nmi_act <= 1'b0;
        else         mask_act <= 1'b0;
      end
      if (taken) begin
        if (vec_q == NMI_VEC) nmi_act  <= 1'b1;
        else                  mask_act <= 1'b1;
      end
    end
  end

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack) |=> (req_q && $stable(vec_q))); // R11
  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && ack) |=> !req_q); // R11
  AST_NO_NMI_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_act |-> !(req_q && vec_q == NMI_VEC)); // R3
  AST_NO_MASK_NEST: assert property (@(posedge clk) disable iff (!rst_n)
    mask_act |-> !(req_q && vec_q != NMI_VEC)); // R4
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (int'(vec_q) <= NUM_MASK)); // R5
  AST_RETI_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && nmi_act && !taken) |=> (!nmi_act && mask_act == $past(mask_act))); // R12
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_EXT = 2,
  parameter int NUM_PER = 2,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_PER-1:0] STOP_MASK = 2'b01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmi_n,
  input  logic               glob_en,
  input  logic [NUM_EXT-1:0] ext_req,
  input  logic [NUM_PER-1:0] per_flag,
  input  logic [NUM_PER-1:0] per_en,
  input  logic               irq_ack,
  input  logic               irq_reti,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec,
  output logic               wake_wait,
  output logic               wake_stop
);
  localparam int NUM_MASK = NUM_EXT + NUM_PER;

  logic                nmi_latch;
  logic                svc_nmi;
  logic [NUM_MASK-1:0] pend;
  logic                any_pend;
  vec_t                win_vec;
  vec_t                vec_q;

  nmi_edge_latch #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
    .clk(clk), .rst_n(rst_n), .pin_n(nmi_n), .svc_clr(svc_nmi), .latch_q(nmi_latch)
  );

  irq_select #(.NUM_EXT(NUM_EXT), .NUM_PER(NUM_PER)) u_sel (
    .glob_en(glob_en), .ext_req(ext_req), .per_flag(per_flag), .per_en(per_en),
    .pend(pend), .any_pend(any_pend), .win_vec(win_vec)
  );

  irq_seq #(.NUM_MASK(NUM_MASK)) u_seq (
    .clk(clk), .rst_n(rst_n), .nmi_pend(nmi_latch), .mask_any(any_pend),
    .mask_win(win_vec), .ack(irq_ack), .reti(irq_reti),
    .req_q(irq_req), .vec_q(vec_q), .svc_nmi(svc_nmi)
  );

  assign irq_vec   = vec_q;
  assign wake_wait = nmi_latch | any_pend;
  assign wake_stop = nmi_latch | (|pend[NUM_EXT-1:0])
                   | (|(pend[NUM_MASK-1:NUM_EXT] & STOP_MASK));

  AST_STOP_IMPLIES_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    wake_stop |-> wake_wait); // R9
  AST_WAIT_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_vec == NMI_VEC && !irq_ack) |-> wake_wait); // R8
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_n = 1'b1;
  logic glob_en = 1'b0;
  logic [1:0] ext_req = 2'b00;
  logic [1:0] per_flag = 2'b00;
  logic [1:0] per_en = 2'b00;
  logic irq_ack = 1'b0;
  logic irq_reti = 1'b0;
  logic irq_req;
  logic [2:0] irq_vec;
  logic wake_wait;
  logic wake_stop;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .glob_en(glob_en), .ext_req(ext_req),
    .per_flag(per_flag), .per_en(per_en), .irq_ack(irq_ack), .irq_reti(irq_reti),
    .irq_req(irq_req), .irq_vec(irq_vec), .wake_wait(wake_wait), .wake_stop(wake_stop)
  );

  // behavioural reference model
  int m_latch, m_nact, m_mact, m_req, m_vec;
  bit pin_hist[$];

  function automatic int pend_mask();
    int p = 0;
    if (glob_en && ext_req[0]) p |= 1;
    if (glob_en && ext_req[1]) p |= 2;
    if (glob_en && per_flag[0] && per_en[0]) p |= 4;
    if (glob_en && per_flag[1] && per_en[1]) p |= 8;
    return p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int p, fall, acked, win, n_latch, n_req, n_vec, n_nact, n_mact;
    if (!rst_n) begin
      m_latch = 0; m_nact = 0; m_mact = 0; m_req = 0; m_vec = 0;
      pin_hist = '{1'b1, 1'b1, 1'b1};
    end else begin
      p = pend_mask();
      fall = (pin_hist[2] && !pin_hist[1]) ? 1 : 0;
      acked = (m_req != 0 && irq_ack) ? 1 : 0;
      win = 0;
      for (int k = 3; k >= 0; k--) if (p[k]) win = k + 1;
      n_latch = (fall != 0 || (m_latch != 0 && !(acked != 0 && m_vec == 0))) ? 1 : 0;
      n_req = m_req; n_vec = m_vec;
      if (m_req != 0) begin
        if (acked != 0) n_req = 0;
      end else if (m_latch != 0 && m_nact == 0) begin
        n_req = 1; n_vec = 0;
      end else if (m_nact == 0 && m_mact == 0 && p != 0) begin
        n_req = 1; n_vec = win;
      end
      n_nact = m_nact; n_mact = m_mact;
      if (irq_reti) begin
        if (m_nact != 0) n_nact = 0; else n_mact = 0;
      end
      if (acked != 0) begin
        if (m_vec == 0) n_nact = 1; else n_mact = 1;
      end
      m_latch = n_latch; m_req = n_req; m_vec = n_vec; m_nact = n_nact; m_mact = n_mact;
      pin_hist.push_front(nmi_n);
      void'(pin_hist.pop_back());
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    int p;
    p = pend_mask();
    chk("R11 model irq_req", int'(irq_req), m_req);
    if (m_req != 0) chk("R5 model irq_vec", int'(irq_vec), m_vec);
    chk("R8 model wake_wait", int'(wake_wait), (m_latch != 0 || p != 0) ? 1 : 0);
    chk("R9 model wake_stop", int'(wake_stop), (m_latch != 0 || (p & 7) != 0) ? 1 : 0);
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      #1;
      compare_model();
    end
  endtask

  task automatic do_ack();
    irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
  endtask

  task automatic do_reti();
    irq_reti = 1'b1; cyc(); irq_reti = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #500000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #12;
    chk("R10 reset irq_req", int'(irq_req), 0);
    chk("R10 reset wake_wait", int'(wake_wait), 0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    cyc(2);

    // R1: NMI with global enable off
    nmi_n = 1'b0;
    cyc(3);
    chk("R1 no request before 4th edge", int'(irq_req), 0);
    chk("R8 wake_wait from nmi latch", int'(wake_wait), 1);
    chk("R9 wake_stop from nmi latch", int'(wake_stop), 1);
    cyc();
    chk("R1 nmi request", int'(irq_req), 1);
    chk("R1 nmi vector", int'(irq_vec), 0);
    cyc(2);
    chk("R11 request held", int'(irq_req), 1);
    do_ack();
    chk("R11 request drops after ack", int'(irq_req), 0);
    cyc(3);
    chk("R2 single edge single request", int'(irq_req), 0);
    chk("R2 latch cleared", int'(wake_wait), 0);
    nmi_n = 1'b1;
    cyc(3);

    // R3: second NMI while NMI in service
    nmi_n = 1'b0;
    cyc(5);
    chk("R3 no nmi nesting", int'(irq_req), 0);
    chk("R3 second nmi stays latched", int'(wake_wait), 1);
    do_reti();
    chk("R12 request after reti edge", int'(irq_req), 0);
    cyc();
    chk("R12 waiting nmi raised", int'(irq_req), 1);
    chk("R12 waiting nmi vector", int'(irq_vec), 0);
    do_ack();
    do_reti();
    nmi_n = 1'b1;
    cyc(3);

    // R5 priority, R4 no maskable nesting
    glob_en = 1'b1; ext_req = 2'b11; per_flag = 2'b11; per_en = 2'b11;
    cyc();
    chk("R5 vector 1 wins", int'(irq_vec), 1);
    do_ack();
    ext_req = 2'b10;
    cyc(3);
    chk("R4 no maskable nesting", int'(irq_req), 0);
    do_reti();
    cyc();
    chk("R5 vector 2 next", int'(irq_vec), 2);
    do_ack(); ext_req = 2'b00; do_reti();
    cyc();
    chk("R5 vector 3 next", int'(irq_vec), 3);
    do_ack(); per_flag = 2'b10; do_reti();
    cyc();
    chk("R5 vector 4 last", int'(irq_vec), 4);
    do_ack(); per_flag = 2'b00; do_reti();
    cyc();
    chk("R5 idle", int'(irq_req), 0);

    // R6 enable gating
    glob_en = 1'b0; per_flag = 2'b01; per_en = 2'b01;
    cyc(3);
    chk("R6 global enable gates", int'(irq_req), 0);
    chk("R8 disabled source no wake", int'(wake_wait), 0);
    glob_en = 1'b1; per_en = 2'b00;
    cyc(2);
    chk("R6 own enable gates", int'(irq_req), 0);
    per_en = 2'b01;
    cyc();
    chk("R6 enabled vector 3", int'(irq_vec), 3);
    chk("R9 vector 3 STOP capable", int'(wake_stop), 1);

    // R3 NMI preempts maskable, R12 reti order, R7 flag not lost
    do_ack();
    nmi_n = 1'b0;
    cyc(4);
    chk("R3 nmi preempts maskable", int'(irq_req), 1);
    chk("R3 preempt vector", int'(irq_vec), 0);
    do_ack();
    nmi_n = 1'b1;
    do_reti();
    cyc(2);
    chk("R12 maskable still in service", int'(irq_req), 0);
    do_reti();
    cyc();
    chk("R7 held flag served", int'(irq_req), 1);
    chk("R7 held flag vector", int'(irq_vec), 3);
    do_ack(); per_flag = 2'b00; do_reti();

    // R9 non STOP-capable source
    per_flag = 2'b10; per_en = 2'b11;
    cyc();
    chk("R9 vector 4 wait only", int'(wake_wait), 1);
    chk("R9 vector 4 no stop", int'(wake_stop), 0);
    do_ack(); per_flag = 2'b00; do_reti();
    cyc(2);

    // R10 reset mid-routine
    per_flag = 2'b01;
    cyc();
    do_ack();
    nmi_n = 1'b0;
    cyc(3);
    rst_n = 1'b0;
    #0.5;
    chk("R10 async reset clears request", int'(irq_req), 0);
    per_flag = 2'b00; nmi_n = 1'b1;
    cyc();
    rst_n = 1'b1;
    cyc(3);
    chk("R10 nothing left after reset", int'(irq_req), 0);
    chk("R10 latch cleared", int'(wake_wait), 0);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) nmi_n = ~nmi_n;
      glob_en  = ($urandom_range(0, 9) != 0);
      ext_req  = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
      per_flag = 2'($urandom);
      per_en   = 2'($urandom);
      irq_ack  = ($urandom_range(0, 2) == 0);
      irq_reti = ($urandom_range(0, 5) == 0);
      cyc();
    end
    irq_ack = 1'b0; irq_reti = 1'b0;
    cyc(2);
    finish_run();
  end
endmodule